// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block gathers a large set of peripheral interrupt sources and sorts them onto six maskable CPU interrupt lines. Every source owns a small control word with a pending flag and an enable. A request pulse on a source sets its flag. The sources that are both flagged and enabled on one line compete in a fixed-priority chain. The winner raises that line's request and presents its position in the chain as a source ID.

A host reaches each source's control word through one flat register window. It can read the flag and the enable, write the enable, and clear the flag by writing a one. When the CPU core acknowledges a line, the block clears the flag of the source whose ID was on that line in that cycle. Any other pending sources on the line stay flagged and take part in the next arbitration. Masking, global interrupt enable and vector fetch belong to the CPU side and are not part of this block.

Top module: `irq_level_router`

## Requirements
- R1: After reset every flag and every enable is 0, every `line_req` bit is 0 and every `line_id` field is 0. A line with no request always presents ID 0.
- R2: A high `src_req[s]` at a clock edge sets source s's flag whether or not its enable is set. The flag reads back as bit 0 of `reg_rdata`.
- R3: A host write (`reg_wr`=1) to address s loads `reg_wdata[1]` into source s's enable. A 1 in `reg_wdata[0]` clears the flag, and a 0 leaves it unchanged. A read returns {enable, flag} in bits [1:0].
- R4: A line is requested only while at least one of its sources has both flag and enable set. A flagged source whose enable is 0 raises no request.
- R5: Within a line, the lowest chain position (0) has the highest priority. `line_id` names the lowest-numbered source that has both flag and enable set.
- R6: Source index s = line*16 + position feeds line `s/16`. `line_id` for line l occupies bits [4*l+3:4*l]. Lines arbitrate independently of each other.
- R7: An acknowledge on a line with its request high clears only the flag of the presented ID. Any remaining candidate is presented right after that edge.
- R8: When a request pulse and a clear (acknowledge or host write-one) hit the same source at the same edge, the flag stays set.
- R9: `line_req` and `line_id` are registers. They take the values implied by the flags and enables that the same clock edge writes. A line's request drops at the edge that clears its last enabled flag.
- R10: An acknowledge on a line whose request is low changes no flag.
- R11: Addresses at or above the number of sources (96) ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 96 | Per-source request pulses, index = line*16 + position |
| reg_sel | input | 7 | Host address: source index |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 2 | Bit 1 enable value, bit 0 write-one-to-clear flag |
| reg_rdata | output | 2 | {enable, flag} of the addressed source |
| line_ack | input | 6 | Per-line acknowledge from the core |
| line_req | output | 6 | Registered per-line interrupt request |
| line_id | output | 24 | Registered winning position per line, 4 bits each |

## Verification
On every cycle the assertions check four things. Each line's request equals the OR of its flagged-and-enabled sources, and the presented ID is the top candidate of the chain. An idle line shows ID 0. Request pulses, enable writes and write-one clears land in the addressed control word, and an acknowledge on an idle line leaves all flags alone. The bench scenarios are needed for the rest. They show the order in which an acknowledge sequence walks through several competing sources and that the group mapping across lines is right. They also cover set-over-clear collisions from both clear paths and the out-of-range host window, all of which depend on a sequence of stimulus rather than a single-cycle relation.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic {
      PICK_SCAN   = 1'b0,
      PICK_ONEHOT = 1'b1
   } pick_impl_e;

   localparam int CTRL_W = 2;

   typedef struct packed {
      logic en;
      logic flag;
   } src_ctrl_t;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int NSRC = 96
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] swclr_i,
   input  logic [NSRC-1:0] ackclr_i,
   input  logic [NSRC-1:0] en_wr_i,
   input  logic            en_val_i,
   output logic [NSRC-1:0] flag_o,
   output logic [NSRC-1:0] en_o,
   output logic [NSRC-1:0] flag_nx_o,
   output logic [NSRC-1:0] en_nx_o
);

   for (genvar s = 0; s < NSRC; s++) begin : g_cell
      // a request at the same edge as any clear keeps the flag set
      always_comb begin
         flag_nx_o[s] = set_i[s] | (flag_o[s] & ~(swclr_i[s] | ackclr_i[s]));
         en_nx_o[s]   = en_wr_i[s] ? en_val_i : en_o[s];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_o[s] <= 1'b0;
            en_o[s]   <= 1'b0;
         end else begin
            flag_o[s] <= flag_nx_o[s];
            en_o[s]   <= en_nx_o[s];
         end
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_router_pkg::*;
#(
   parameter int         SRC_PER_LINE = 16,
   parameter int         ID_W         = 4,
   parameter pick_impl_e PICK_IMPL    = PICK_SCAN
) (
   input  logic [SRC_PER_LINE-1:0] pend_i,
   output logic                    hit_o,
   output logic [ID_W-1:0]         id_o
);

   assign hit_o = |pend_i;

   if (PICK_IMPL == PICK_SCAN) begin : g_scan
      // walk from the bottom of the chain up; the last match is position 0 side
      always_comb begin
         id_o = '0;
         for (int p = SRC_PER_LINE - 1; p >= 0; p--) begin
            if (pend_i[p]) id_o = ID_W'(p);
         end
      end
   end else begin : g_onehot
      logic [SRC_PER_LINE-1:0] lowest;
      assign lowest = pend_i & (~pend_i + SRC_PER_LINE'(1));
      always_comb begin
         id_o = '0;
         for (int p = 0; p < SRC_PER_LINE; p++) begin
            if (lowest[p]) id_o = id_o | ID_W'(p);
         end
      end
   end

endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hit_i,
   input  logic [ID_W-1:0] id_i,
   output logic            req_o,
   output logic [ID_W-1:0] id_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o <= 1'b0;
         id_o  <= '0;
      end else begin
         req_o <= hit_i;
         id_o  <= hit_i ? id_i : '0;
      end
   end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
   import irq_router_pkg::*;
#(
   parameter int         NUM_LINES    = 6,
   parameter int         SRC_PER_LINE = 16,
   parameter pick_impl_e PICK_IMPL    = PICK_SCAN,
   localparam int        NSRC         = NUM_LINES * SRC_PER_LINE,
   localparam int        ID_W         = (SRC_PER_LINE > 1) ? $clog2(SRC_PER_LINE) : 1,
   localparam int        ADDR_W       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           src_req,
   input  logic [ADDR_W-1:0]         reg_sel,
   input  logic                      reg_wr,
   input  logic [CTRL_W-1:0]         reg_wdata,
   output logic [CTRL_W-1:0]         reg_rdata,
   input  logic [NUM_LINES-1:0]      line_ack,
   output logic [NUM_LINES-1:0]      line_req,
   output logic [NUM_LINES*ID_W-1:0] line_id
);

   if (NUM_LINES < 1 || NUM_LINES > 16) begin : g_bad_lines
      $error("irq_level_router: NUM_LINES out of range");
   end
   if (SRC_PER_LINE < 2 || SRC_PER_LINE > 16) begin : g_bad_depth
      $error("irq_level_router: SRC_PER_LINE out of range");
   end

   logic [NSRC-1:0] wr_hit, swclr, ackclr;
   logic [NSRC-1:0] flag_q, en_q, flag_nx, en_nx;
   src_ctrl_t       wdat, rdat;

   assign wdat = src_ctrl_t'(reg_wdata);

   // host window decode
   always_comb begin
      rdat = '0;
      for (int s = 0; s < NSRC; s++) begin
         wr_hit[s] = reg_wr && (reg_sel == ADDR_W'(s));
         swclr[s]  = wr_hit[s] && wdat.flag;
         if (reg_sel == ADDR_W'(s)) begin
            rdat.flag = flag_q[s];
            rdat.en   = en_q[s];
         end
      end
   end
   assign reg_rdata = rdat;

   // acknowledge decode: clear the presented winner of each requesting line
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_ack
      for (genvar p = 0; p < SRC_PER_LINE; p++) begin : g_pos
         assign ackclr[l*SRC_PER_LINE + p] =
            line_ack[l] && line_req[l] && (line_id[l*ID_W +: ID_W] == ID_W'(p));
      end
   end

   irq_src_bank #(.NSRC(NSRC)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (src_req),
      .swclr_i   (swclr),
      .ackclr_i  (ackclr),
      .en_wr_i   (wr_hit),
      .en_val_i  (wdat.en),
      .flag_o    (flag_q),
      .en_o      (en_q),
      .flag_nx_o (flag_nx),
      .en_nx_o   (en_nx)
   );

   // arbitration on next-state values so the line registers track the bank
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [SRC_PER_LINE-1:0] pend_nx;
      logic                    hit;
      logic [ID_W-1:0]         win;

      assign pend_nx = flag_nx[l*SRC_PER_LINE +: SRC_PER_LINE]
                     & en_nx[l*SRC_PER_LINE +: SRC_PER_LINE];

      irq_prio_pick #(
         .SRC_PER_LINE (SRC_PER_LINE),
         .ID_W         (ID_W),
         .PICK_IMPL    (PICK_IMPL)
      ) u_pick (
         .pend_i (pend_nx),
         .hit_o  (hit),
         .id_o   (win)
      );

      irq_line_reg #(.ID_W(ID_W)) u_lreg (
         .clk   (clk),
         .rst_n (rst_n),
         .hit_i (hit),
         .id_i  (win),
         .req_o (line_req[l]),
         .id_o  (line_id[l*ID_W +: ID_W])
      );
   end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_LINES    = 6,
   parameter int SRC_PER_LINE = 16,
   parameter int ID_W         = 4,
   parameter int ADDR_W       = 7
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_LINES*SRC_PER_LINE-1:0] src_req,
   input logic [ADDR_W-1:0]                 reg_sel,
   input logic                              reg_wr,
   input logic [1:0]                        reg_wdata,
   input logic [NUM_LINES-1:0]              line_ack,
   input logic [NUM_LINES-1:0]              line_req,
   input logic [NUM_LINES*ID_W-1:0]         line_id,
   input logic [NUM_LINES*SRC_PER_LINE-1:0] flag_q,
   input logic [NUM_LINES*SRC_PER_LINE-1:0] en_q
);

   localparam int NSRC = NUM_LINES * SRC_PER_LINE;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
      logic [SRC_PER_LINE-1:0] pend, grp_flag, below;
      logic [ID_W-1:0]         id;

      assign grp_flag = flag_q[l*SRC_PER_LINE +: SRC_PER_LINE];
      assign pend     = grp_flag & en_q[l*SRC_PER_LINE +: SRC_PER_LINE];
      assign id       = line_id[l*ID_W +: ID_W];
      assign below    = (SRC_PER_LINE'(1) << id) - SRC_PER_LINE'(1);

      // R9
      req_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
         line_req[l] == (|pend));

      // R5
      winner_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
         line_req[l] |-> (pend[id] && ((pend & below) == '0)));

      // R1
      idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !line_req[l] |-> (id == '0));

      // R10
      idle_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (line_ack[l] && !line_req[l] && !reg_wr) |=>
            ((grp_flag & $past(grp_flag)) == $past(grp_flag)));
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_s
      // R8
      request_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         src_req[s] |=> flag_q[s]);

      // R3
      enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_sel == ADDR_W'(s)) |=> (en_q[s] == $past(reg_wdata[1])));

      // R3
      sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_sel == ADDR_W'(s) && reg_wdata[0] && !src_req[s]) |=> !flag_q[s]);
   end

endmodule

bind irq_level_router irq_router_chk #(
   .NUM_LINES    (NUM_LINES),
   .SRC_PER_LINE (SRC_PER_LINE),
   .ID_W         (ID_W),
   .ADDR_W       (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_req   (src_req),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .line_ack  (line_ack),
   .line_req  (line_req),
   .line_id   (line_id),
   .flag_q    (flag_q),
   .en_q      (en_q)
);

// File: tb/tb_irq_level_router.sv
module tb_irq_level_router;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 6;
   localparam int SP = 16;
   localparam int NS = NL * SP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic [6:0]    reg_sel = '0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_wdata = '0;
   logic [1:0]    reg_rdata;
   logic [NL-1:0] line_ack = '0;
   logic [NL-1:0] line_req;
   logic [NL*4-1:0] line_id;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      bit    is_reg;
      int    idx;
      int    exp;
      string tag;
   } item_t;

   item_t sb[$];

   irq_level_router dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_req   (src_req),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .line_ack  (line_ack),
      .line_req  (line_req),
      .line_id   (line_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pop expectations and compare away from the rising edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         int act;
         it = sb.pop_front();
         if (it.is_reg) act = int'(reg_rdata);
         else act = int'({line_req[it.idx], line_id[it.idx*4 +: 4]});
         checks++;
         if (act != it.exp) begin
            errors++;
            $display("FAIL %s %s %0d: actual=%0h expected=%0h",
                     it.tag, it.is_reg ? "reg" : "line", it.idx, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   // expected line state: req bit and ID
   task automatic chk_line(int l, bit req, int id, string tag);
      item_t it;
      it.is_reg = 0; it.idx = l; it.exp = (int'(req) << 4) | id; it.tag = tag;
      sb.push_back(it);
      settle();
   endtask

   // expected {enable, flag} readback
   task automatic chk_reg(int a, int val, string tag);
      item_t it;
      reg_sel = 7'(a);
      it.is_reg = 1; it.idx = a; it.exp = val; it.tag = tag;
      sb.push_back(it);
      settle();
   endtask

   task automatic host_wr(int a, logic [1:0] d);
      reg_sel = 7'(a); reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(int s);
      src_req[s] = 1'b1;
      step();
      src_req = '0;
   endtask

   task automatic ack(int l);
      line_ack[l] = 1'b1;
      step();
      line_ack = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      for (int l = 0; l < NL; l++) chk_line(l, 0, 0, "R1");
      chk_reg(5, 0, "R1");

      // R2 / R4: flag set while disabled, no request
      pulse(3);
      chk_reg(3, 2'b01, "R2");
      chk_line(0, 0, 0, "R4");

      // R3 / R9: enable write, request visible right after that edge
      host_wr(3, 2'b10);
      chk_reg(3, 2'b11, "R3");
      chk_line(0, 1, 3, "R9");

      // R5: competing sources, position 1 wins over 3 and 9
      host_wr(1, 2'b10);
      host_wr(9, 2'b10);
      src_req[1] = 1'b1; src_req[9] = 1'b1;
      step();
      src_req = '0;
      chk_line(0, 1, 1, "R5");

      // R7: acknowledge walks the chain
      ack(0);
      chk_line(0, 1, 3, "R7");
      chk_reg(1, 2'b10, "R7");
      chk_reg(9, 2'b11, "R7");
      ack(0);
      chk_line(0, 1, 9, "R7");
      ack(0);
      chk_line(0, 0, 0, "R9");

      // R10: acknowledge on idle line keeps a disabled pending flag
      pulse(7);
      ack(0);
      chk_reg(7, 2'b01, "R10");
      // R3: writing 0 to the flag bit keeps it, writing 1 clears it
      host_wr(7, 2'b00);
      chk_reg(7, 2'b01, "R3");
      host_wr(7, 2'b01);
      chk_reg(7, 2'b00, "R3");

      // R6: group mapping across lines
      host_wr(36, 2'b10);
      host_wr(95, 2'b10);
      src_req[36] = 1'b1; src_req[95] = 1'b1;
      step();
      src_req = '0;
      chk_line(2, 1, 4, "R6");
      chk_line(5, 1, 15, "R6");
      chk_line(0, 0, 0, "R6");
      chk_line(3, 0, 0, "R6");

      // R8: set beats acknowledge clear and host clear at the same edge
      line_ack[2] = 1'b1; src_req[36] = 1'b1;
      step();
      line_ack = '0; src_req = '0;
      chk_line(2, 1, 4, "R8");
      reg_sel = 7'd95; reg_wdata = 2'b11; reg_wr = 1'b1; src_req[95] = 1'b1;
      step();
      reg_wr = 1'b0; reg_wdata = '0; src_req = '0;
      chk_reg(95, 2'b11, "R8");

      // R7 / R9: last flag of line 2 cleared
      ack(2);
      chk_line(2, 0, 0, "R9");
      chk_reg(36, 2'b10, "R7");

      // R4: disabling drops the request but the flag stays
      host_wr(95, 2'b00);
      chk_line(5, 0, 0, "R4");
      chk_reg(95, 2'b01, "R4");

      // R11: out-of-range window
      host_wr(100, 2'b10);
      chk_reg(100, 0, "R11");
      chk_reg(127, 0, "R11");
      for (int l = 0; l < NL; l++) chk_line(l, 0, 0, "R11");

      settle();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule